// File: doc/BRIEF.md
# Flag-Qualified Word Transfer Between Clock Domains

This block carries one wide data word at a time from a slow source clock domain into a faster destination clock domain. No FIFO is involved. The source side latches the word into a holding register. One source cycle later it changes a single request flag. Only that flag crosses into the destination, through a two-flop synchroniser. When the destination sees the flag change, it captures the whole held word at once and emits a one-cycle valid pulse.

The destination then returns an acknowledge toggle, which is synchronised back into the source. Until that acknowledge arrives the source reports busy and keeps the held word frozen. A load attempted during that time is discarded and sets a sticky overrun flag.

A typical use is moving a snapshot of several 16-bit converter samples into a faster processing clock. The data width is a parameter; the default is 160 bits, which is ten 16-bit channels. The scheme assumes the destination clock is faster than the source clock.

Top module: `flag_xfer_bridge`

## Requirements
- R1: While either reset is asserted and right after it is released, `src_busy`, `src_overrun` and `dst_valid` are 0.
- R2: A source-clock edge with `src_load` high and `src_busy` low accepts `src_word`, and `src_busy` reads 1 after that edge.
- R3: While the source is busy, the held word presented to the destination does not change.
- R4: The request flag changes only in a source cycle that follows a cycle in which the word was already held, so it always trails the data load by at least one source cycle.
- R5: Every accepted word appears exactly once on `dst_word`, together with a `dst_valid` pulse, in the order the words were accepted, with all bits from the same load.
- R6: After the destination captures a word, `src_busy` returns to 0 within 6 source cycles.
- R7: A source-clock edge with `src_load` high while `src_busy` is 1 does not disturb the word in flight or what is delivered, and it sets `src_overrun`. `src_overrun` then stays 1 until source reset.
- R8: `dst_valid` is never high on two consecutive destination cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source (slow) clock |
| src_rst_n | input | 1 | Source asynchronous active-low reset |
| src_load | input | 1 | Request to load `src_word` |
| src_word | input | DATA_W | Word to transfer |
| src_busy | output | 1 | Transfer in flight; loads are refused |
| src_overrun | output | 1 | Sticky: a load was refused while busy |
| dst_clk | input | 1 | Destination (fast) clock |
| dst_rst_n | input | 1 | Destination asynchronous active-low reset |
| dst_word | output | DATA_W | Captured word |
| dst_valid | output | 1 | One-cycle pulse when `dst_word` is new |

## Verification
Two things can fall into the same source cycle: a new load request, and the acknowledge that ends the previous transfer. The bench provokes this by holding `src_load` high with a word that changes every source cycle, across the moment busy falls. Every cycle refused before release must raise the overrun flag. The word from the first cycle in which busy reads low must be the next one delivered, intact. No word from the refused cycles may arrive.

// File: rtl/flag_xfer_pkg.sv
package flag_xfer_pkg;
  localparam int unsigned DEF_DATA_W   = 160;
  localparam int unsigned DEF_SYNC_LEN = 2;
endpackage

// File: rtl/fx_reset_sync.sv
module fx_reset_sync #(
  parameter int unsigned LEN = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [LEN-1:0] chain_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[LEN-2:0], 1'b1};
  end
  assign rst_n = chain_q[LEN-1];
endmodule

// File: rtl/fx_bit_sync.sv
module fx_bit_sync #(
  parameter int unsigned LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [LEN-1:0] stage_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[LEN-2:0], d};
  end
  assign q = stage_q[LEN-1];
endmodule

// File: rtl/fx_src_side.sv
module fx_src_side #(
  parameter int unsigned DATA_W   = 160,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] word,
  input  logic              ack_tgl,
  output logic              busy,
  output logic              overrun,
  output logic              req_tgl,
  output logic [DATA_W-1:0] hold_word
);
  logic              busy_q, busy_d;
  logic              flip_q, flip_d;
  logic              req_q, req_d;
  logic              ovr_q, ovr_d;
  logic [DATA_W-1:0] hold_q;
  logic              hold_en;
  logic              ack_s;
  logic              accept;
  logic              ack_home;

  fx_bit_sync #(.LEN(SYNC_LEN)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_tgl), .q(ack_s)
  );

  always_comb begin
    accept   = load && !busy_q;
    ack_home = busy_q && !flip_q && (ack_s == req_q);
    hold_en  = accept;
    flip_d   = accept;
    req_d    = flip_q ? ~req_q : req_q;
    busy_d   = busy_q;
    if (accept)        busy_d = 1'b1;
    else if (ack_home) busy_d = 1'b0;
    ovr_d    = ovr_q || (load && busy_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      flip_q <= 1'b0;
      req_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      flip_q <= flip_d;
      req_q  <= req_d;
      ovr_q  <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= word;
  end

  assign busy      = busy_q;
  assign overrun   = ovr_q;
  assign req_tgl   = req_q;
  assign hold_word = hold_q;

  // R2
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !busy) |=> busy);
  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(hold_word));
  // R4
  req_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_tgl != $past(req_tgl)) |-> ($past(busy) && busy));
  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && busy) |=> overrun);
endmodule

// File: rtl/fx_dst_side.sv
module fx_dst_side #(
  parameter int unsigned DATA_W   = 160,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_tgl,
  input  logic [DATA_W-1:0] hold_word,
  output logic              ack_tgl,
  output logic [DATA_W-1:0] word,
  output logic              valid
);
  logic              req_s;
  logic              seen_q;
  logic              take;
  logic              valid_q;
  logic [DATA_W-1:0] word_q;

  fx_bit_sync #(.LEN(SYNC_LEN)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req_tgl), .q(req_s)
  );

  always_comb take = req_s ^ seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      seen_q  <= req_s;
      valid_q <= take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (take) word_q <= hold_word;
  end

  assign ack_tgl = seen_q;
  assign word    = word_q;
  assign valid   = valid_q;

  // R8
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  // R5
  word_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(word));
endmodule

// File: rtl/flag_xfer_bridge.sv
module flag_xfer_bridge
  import flag_xfer_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned SYNC_LEN = DEF_SYNC_LEN
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              src_load,
  input  logic [DATA_W-1:0] src_word,
  output logic              src_busy,
  output logic              src_overrun,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic [DATA_W-1:0] dst_word,
  output logic              dst_valid
);
  logic              s_rst_n, d_rst_n;
  logic              req_tgl, ack_tgl;
  logic [DATA_W-1:0] hold_word;

  fx_reset_sync #(.LEN(SYNC_LEN)) u_src_rst (
    .clk(src_clk), .arst_n(src_rst_n), .rst_n(s_rst_n)
  );
  fx_reset_sync #(.LEN(SYNC_LEN)) u_dst_rst (
    .clk(dst_clk), .arst_n(dst_rst_n), .rst_n(d_rst_n)
  );

  fx_src_side #(.DATA_W(DATA_W), .SYNC_LEN(SYNC_LEN)) u_src (
    .clk(src_clk), .rst_n(s_rst_n), .load(src_load), .word(src_word),
    .ack_tgl(ack_tgl), .busy(src_busy), .overrun(src_overrun),
    .req_tgl(req_tgl), .hold_word(hold_word)
  );

  fx_dst_side #(.DATA_W(DATA_W), .SYNC_LEN(SYNC_LEN)) u_dst (
    .clk(dst_clk), .rst_n(d_rst_n), .req_tgl(req_tgl), .hold_word(hold_word),
    .ack_tgl(ack_tgl), .word(dst_word), .valid(dst_valid)
  );
endmodule

// File: tb/tb_flag_xfer_bridge.sv
module tb_flag_xfer_bridge;
  localparam int W = 160;
  logic src_clk = 0, dst_clk = 0;
  logic src_rst_n = 0, dst_rst_n = 0;
  logic src_load = 0;
  logic [W-1:0] src_word = '0;
  logic src_busy, src_overrun, dst_valid;
  logic [W-1:0] dst_word;

  int tests = 0, fails = 0;
  logic [W-1:0] expq[$];
  int delivered = 0;
  int since_cap = -1;
  bit done = 0;

  always #10 dst_clk = ~dst_clk;
  always #35 src_clk = ~src_clk;

  flag_xfer_bridge #(.DATA_W(W)) dut (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_load(src_load),
    .src_word(src_word), .src_busy(src_busy), .src_overrun(src_overrun),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_word(dst_word),
    .dst_valid(dst_valid)
  );

  function automatic logic [W-1:0] mk(input int k);
    logic [W-1:0] v;
    for (int i = 0; i < W/16; i++) v[i*16 +: 16] = 16'(k * 37 + i * 4099 + 16'h5a00);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model on every destination clock: R5, R8
  logic prev_valid = 0;
  always @(negedge dst_clk) begin
    if (dst_rst_n && src_rst_n) begin
      if (dst_valid) begin
        check(!prev_valid, "R8 valid twice", W'(1), W'(0));
        if (expq.size() == 0) check(0, "R5 unexpected word", dst_word, '0);
        else begin
          check(dst_word == expq[0], "R5 word", dst_word, expq[0]);
          void'(expq.pop_front());
        end
        delivered++;
        since_cap = 0;
      end
      prev_valid = dst_valid;
    end
  end

  // Reference model on every source clock: R6
  always @(negedge src_clk) begin
    if (since_cap >= 0) begin
      if (!src_busy) since_cap = -1;
      else begin
        since_cap++;
        if (since_cap > 6) begin
          check(0, "R6 busy stuck", W'(src_busy), W'(0));
          since_cap = -1;
        end
      end
    end
  end

  task automatic send(input logic [W-1:0] v);
    @(negedge src_clk);
    while (src_busy) @(negedge src_clk);
    src_load = 1; src_word = v;
    expq.push_back(v);
    @(negedge src_clk);
    src_load = 0;
    check(src_busy == 1, "R2 busy after accept", W'(src_busy), W'(1));
  endtask

  task automatic drain();
    int n = 0;
    while ((expq.size() != 0 || src_busy) && n < 200) begin
      @(negedge src_clk); n++;
    end
  endtask

  initial begin
    #100000000;
    check(0, "watchdog", '0, '0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge src_clk);
    // R1 during reset
    check(!src_busy && !src_overrun, "R1 in reset", W'({src_busy, src_overrun}), '0);
    check(!dst_valid, "R1 dst_valid in reset", W'(dst_valid), '0);
    src_rst_n = 1; dst_rst_n = 1;
    repeat (4) @(negedge src_clk);
    check(!src_busy && !src_overrun, "R1 after reset", W'({src_busy, src_overrun}), '0);

    // R5 several patterns
    send('0);
    send('1);
    send({5{32'hA5A5_5A5A}});
    for (int k = 1; k < 8; k++) send(mk(k));
    drain();
    check(expq.size() == 0 && delivered == 10, "R5 all delivered",
          W'(delivered), W'(10));
    check(!src_overrun, "R7 no overrun yet", W'(src_overrun), '0);

    // R7 load while busy is dropped, overrun set
    send(mk(100));
    src_load = 1; src_word = mk(999);
    @(negedge src_clk);
    src_load = 0;
    check(src_overrun == 1, "R7 overrun set", W'(src_overrun), W'(1));
    drain();
    check(delivered == 11, "R7 dropped word not delivered", W'(delivered), W'(11));

    // Load held across busy release: first cycle with busy low wins
    send(mk(200));
    begin
      int k = 300;
      forever begin
        src_load = 1; src_word = mk(k);
        if (!src_busy) break;
        @(negedge src_clk);
        k++;
      end
      expq.push_back(mk(k));
      @(negedge src_clk);
      src_load = 0;
      check(src_busy == 1, "R2 accept on release", W'(src_busy), W'(1));
    end
    drain();
    check(delivered == 13, "R5 release-cycle word", W'(delivered), W'(13));
    check(src_overrun == 1, "R7 overrun sticky", W'(src_overrun), W'(1));

    // R1 source reset clears overrun
    src_rst_n = 0;
    @(negedge src_clk);
    check(!src_overrun && !src_busy, "R1 source reset", W'(src_overrun), '0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule